// File: doc/BRIEF.md
# SPI TPM Transaction Engine with Hardware Wait-State Polling

This block is a half-duplex SPI host that carries out one TPM register access per request. A request gives a direction, a 16-bit register address and a byte count. For each frame the engine lowers chip select once and sends a command byte, a fixed start byte, the address high byte and the address low byte. It then either sends write data on MOSI or collects read data from MISO. Write bytes are pulled from a valid/ready byte stream. Read bytes leave on a valid-only byte stream. A single response pulse ends the request and carries a timeout flag.

The target can stall the transfer. It does this by holding MISO low on the clock of the final address bit. The engine samples that bit in hardware. If it is low, the engine clocks zero-filled wait bytes until the last bit of one of them comes back high. The number of wait bytes is bounded by a limit input. If the limit runs out, the frame is abandoned and a timeout is reported. Requests longer than the maximum frame size are cut into consecutive frames. Every frame uses the same address, so the data stream continues across frames into a FIFO-style register. SCK runs in SPI mode 0 at a rate set by a divider of the system clock.

Top module: `tpm_spi_engine`

## Requirements
- R1: Byte 0 of every frame is the command byte. Bit 7 is 1 for a read and 0 for a write. The low log2(MAX_FRAME) bits hold the frame length minus one. The remaining bits below bit 7 are 0.
- R2: Bytes 1 to 3 of every frame are 0xD4, then the address high byte, then the address low byte. Every frame of a request repeats the same address, with no increment.
- R3: SPI mode 0 with MSB first. SCK is low whenever chip select is high. During the data phase of a read, MOSI carries only zeros.
- R4: If MISO is 1 on the last address bit, the data phase starts directly after the address low byte, with no extra bytes.
- R5: If MISO is 0 on the last address bit, the engine sends 0x00 wait bytes. It starts data after the first wait byte whose final bit samples 1.
- R6: If cfg_wait_limit wait bytes pass without a ready bit, the engine raises chip select and moves no data. This also applies at once when the limit is 0. The response then carries rsp_timeout = 1, and the rest of the request is dropped.
- R7: A request of L bytes is sent as ceil(L/MAX_FRAME) frames. All frames are full except the last, which carries the remainder.
- R8: Between frames of one request, chip select stays high for at least one SCK period, which is 2*(cfg_div+1) clock cycles.
- R9: Write bytes are taken one per wr_valid/wr_ready handshake, in order, and sent in that order across frames. A successful write consumes exactly L bytes.
- R10: Read bytes appear on rd_data with a one-cycle rd_valid pulse each, in the order received, L in total.
- R11: req_ready is high only while the engine is idle. Each accepted request ends with exactly one one-cycle rsp_valid pulse. rsp_timeout is 0 when the request succeeds.
- R12: A request of length 0 causes no bus activity and is answered with rsp_timeout = 0.
- R13: Every SCK high phase lasts exactly cfg_div+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIVW | SCK half period minus one, in clock cycles |
| cfg_wait_limit | input | WAITW | Maximum number of wait bytes before timeout |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 16 | TPM register address |
| req_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Engine takes a write byte this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte pulse |
| rd_data | output | 8 | Read byte |
| rsp_valid | output | 1 | Request finished pulse |
| rsp_timeout | output | 1 | Request ended by wait-limit timeout |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Host-to-target data |
| spi_miso | input | 1 | Target-to-host data |

## Verification
The bench uses MAX_FRAME = 8, DIVW = 4, WAITW = 4 and LEN_W = 8. The 8-byte frame lets a sweep over every length from 0 to 20 cover single frames, exact multiples and remainders. The 3-bit length field also makes a wrong header bit easy to see. Divider values 0, 1 and 2 combined with 0 to 4 target wait bytes and limits of 0 and 3 cover three cases: immediate ready, ready on the last permitted wait byte, and timeout, including a timeout at the address bit itself. A target model in the bench computes the expected frames and data patterns from the address, the length and a byte index.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_ADDR, ST_POLL, ST_FETCH, ST_DATA, ST_GAP, ST_RESP
  } eng_state_t;

  // fixed byte that follows the command byte on the wire
  localparam logic [7:0] TPM_START_BYTE = 8'hD4;
endpackage

// File: rtl/tpm_spi_halftick.sv
// Half-period strobe for SCK; counts only while enabled.
module tpm_spi_halftick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en)       cnt_q <= '0;
    else if (cnt_q >= div) cnt_q <= '0;
    else                  cnt_q <= cnt_q + DIVW'(1);
  end

  assign tick = en && (cnt_q >= div);
endmodule

// File: rtl/tpm_spi_byte_io.sv
// One mode-0 byte: rise samples MISO, fall shifts MOSI.
module tpm_spi_byte_io (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       busy,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  logic [2:0] bit_q;
  logic [7:0] tx_q, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sck   <= 1'b0;
      done  <= 1'b0;
      bit_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy  <= 1'b1;
        sck   <= 1'b0;
        bit_q <= '0;
        tx_q  <= tx;
      end else if (busy && tick) begin
        if (!sck) begin
          sck  <= 1'b1;
          rx_q <= {rx_q[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_q == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi = tx_q[7];
  assign rx   = rx_q;
endmodule

// File: rtl/tpm_spi_engine.sv
module tpm_spi_engine import tpm_spi_pkg::*; #(
  parameter int MAX_FRAME = 64,
  parameter int DIVW      = 8,
  parameter int WAITW     = 8,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIVW-1:0]  cfg_div,
  input  logic [WAITW-1:0] cfg_wait_limit,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_read,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rsp_valid,
  output logic             rsp_timeout,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int FLW  = $clog2(MAX_FRAME);
  localparam int CNTW = FLW + 1;

  function automatic logic [CNTW-1:0] frame_len(input logic [LEN_W-1:0] rem);
    if (rem >= LEN_W'(MAX_FRAME)) return CNTW'(MAX_FRAME);
    return rem[CNTW-1:0];
  endfunction

  function automatic logic [7:0] hdr_byte(input logic rd, input logic [CNTW-1:0] fl);
    logic [7:0] h;
    h    = 8'(fl - CNTW'(1));
    h[7] = rd;
    return h;
  endfunction

  eng_state_t       st_q;
  logic [CNTW-1:0]  flen_q, fcnt_q, next_fl;
  logic [LEN_W-1:0] remain_q;
  logic [15:0]      addr_q;
  logic [1:0]       aidx_q;
  logic [WAITW-1:0] polls_q;
  logic             rd_q, err_q, gap_q, cs_n_q;
  logic             sh_go, sh_busy, sh_done, tick;
  logic [7:0]       sh_tx, sh_rx;

  always_comb next_fl = frame_len((st_q == ST_IDLE) ? req_len : remain_q);

  assign req_ready = (st_q == ST_IDLE);
  assign wr_ready  = (st_q == ST_FETCH) && !rd_q;
  assign spi_cs_n  = cs_n_q;

  tpm_spi_halftick #(.DIVW(DIVW)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (sh_busy || (st_q == ST_GAP)),
    .div  (cfg_div),
    .tick (tick)
  );

  tpm_spi_byte_io u_io (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .go   (sh_go),
    .tx   (sh_tx),
    .miso (spi_miso),
    .busy (sh_busy),
    .sck  (spi_sck),
    .mosi (spi_mosi),
    .done (sh_done),
    .rx   (sh_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      flen_q      <= '0;
      fcnt_q      <= '0;
      remain_q    <= '0;
      addr_q      <= '0;
      aidx_q      <= '0;
      polls_q     <= '0;
      rd_q        <= 1'b0;
      err_q       <= 1'b0;
      gap_q       <= 1'b0;
      cs_n_q      <= 1'b1;
      sh_go       <= 1'b0;
      sh_tx       <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      rsp_valid   <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      sh_go     <= 1'b0;
      rd_valid  <= 1'b0;
      rsp_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          rd_q     <= req_read;
          addr_q   <= req_addr;
          remain_q <= req_len;
          err_q    <= 1'b0;
          if (req_len == '0) st_q <= ST_RESP;
          else begin
            flen_q <= next_fl;
            fcnt_q <= '0;
            cs_n_q <= 1'b0;
            sh_tx  <= hdr_byte(req_read, next_fl);
            sh_go  <= 1'b1;
            st_q   <= ST_HDR;
          end
        end
        ST_HDR: if (sh_done) begin
          sh_tx  <= TPM_START_BYTE;
          sh_go  <= 1'b1;
          aidx_q <= 2'd0;
          st_q   <= ST_ADDR;
        end
        ST_ADDR: if (sh_done) begin
          if (aidx_q == 2'd0) begin
            sh_tx <= addr_q[15:8]; sh_go <= 1'b1; aidx_q <= 2'd1;
          end else if (aidx_q == 2'd1) begin
            sh_tx <= addr_q[7:0];  sh_go <= 1'b1; aidx_q <= 2'd2;
          end else if (sh_rx[0]) begin
            st_q <= ST_FETCH;
          end else if (cfg_wait_limit == '0) begin
            cs_n_q <= 1'b1; err_q <= 1'b1; remain_q <= '0; gap_q <= 1'b0; st_q <= ST_GAP;
          end else begin
            sh_tx <= 8'h00; sh_go <= 1'b1; polls_q <= WAITW'(1); st_q <= ST_POLL;
          end
        end
        ST_POLL: if (sh_done) begin
          if (sh_rx[0]) st_q <= ST_FETCH;
          else if (polls_q >= cfg_wait_limit) begin
            cs_n_q <= 1'b1; err_q <= 1'b1; remain_q <= '0; gap_q <= 1'b0; st_q <= ST_GAP;
          end else begin
            sh_tx <= 8'h00; sh_go <= 1'b1; polls_q <= polls_q + WAITW'(1);
          end
        end
        ST_FETCH: begin
          if (rd_q) begin
            sh_tx <= 8'h00; sh_go <= 1'b1; st_q <= ST_DATA;
          end else if (wr_valid) begin
            sh_tx <= wr_data; sh_go <= 1'b1; st_q <= ST_DATA;
          end
        end
        ST_DATA: if (sh_done) begin
          if (rd_q) begin
            rd_data  <= sh_rx;
            rd_valid <= 1'b1;
          end
          remain_q <= remain_q - LEN_W'(1);
          fcnt_q   <= fcnt_q + CNTW'(1);
          if (fcnt_q + CNTW'(1) == flen_q) begin
            cs_n_q <= 1'b1; gap_q <= 1'b0; st_q <= ST_GAP;
          end else st_q <= ST_FETCH;
        end
        ST_GAP: if (tick) begin
          if (!gap_q) gap_q <= 1'b1;
          else if (remain_q == '0) st_q <= ST_RESP;
          else begin
            flen_q <= next_fl;
            fcnt_q <= '0;
            cs_n_q <= 1'b0;
            sh_tx  <= hdr_byte(rd_q, next_fl);
            sh_go  <= 1'b1;
            st_q   <= ST_HDR;
          end
        end
        ST_RESP: begin
          rsp_valid   <= 1'b1;
          rsp_timeout <= err_q;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpm_spi_engine_chk.sv
module tpm_spi_engine_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rsp_valid,
  input logic             rsp_timeout,
  input logic             spi_sck,
  input logic             spi_cs_n
);
  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  // R6
  timeout_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_timeout) |-> spi_cs_n);

  // R11
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R12
  zero_len_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == '0) |=> spi_cs_n);

  // R9
  wr_take_once_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R9
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !spi_cs_n);

  // R10
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R8
  cs_gap_min_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> spi_cs_n);
endmodule

bind tpm_spi_engine tpm_spi_engine_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_len     (req_len),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .rd_valid    (rd_valid),
  .rsp_valid   (rsp_valid),
  .rsp_timeout (rsp_timeout),
  .spi_sck     (spi_sck),
  .spi_cs_n    (spi_cs_n)
);

// File: tb/tpm_spi_engine_tb.sv
module tpm_spi_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF  = 8;
  localparam int DIVW  = 4;
  localparam int WAITW = 4;
  localparam int LEN_W = 8;

  logic clk, rst;
  logic [DIVW-1:0]  cfg_div;
  logic [WAITW-1:0] cfg_wait_limit;
  logic req_valid, req_ready, req_read;
  logic [15:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic rd_valid;
  logic [7:0] rd_data;
  logic rsp_valid, rsp_timeout;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  tpm_spi_engine #(.MAX_FRAME(MAXF), .DIVW(DIVW), .WAITW(WAITW), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_wait_limit(cfg_wait_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rpat(input int i);
    return 8'(i * 29 + 90);
  endfunction
  function automatic logic [7:0] wpat(input int i);
    return 8'(i * 53 + 195);
  endfunction

  // ---------------- target model ----------------
  bit          t_rd;
  logic [15:0] t_addr;
  int t_waits, t_limit, t_remain, t_base, t_frames, t_bits, t_wglob;
  int e_hdr, e_addr, e_poll, e_len, e_wdata, e_rmosi, e_gap, e_half, e_rd;
  logic [7:0] fb [0:255];
  logic [7:0] t_sh;
  time t_hi, t_rise;
  int rd_seen, wr_idx;
  bit take;

  initial begin
    t_bits = 0; t_frames = 0; t_wglob = 0; t_waits = 0; t_limit = 0;
    t_hi = 0; t_rise = 0; t_sh = '0; spi_miso = 1'b0;
    rd_seen = 0; wr_idx = 0; take = 1'b0;
  end

  function automatic logic miso_bit(input int b);
    int k, p, j;
    logic [7:0] v;
    k = b / 8; p = b % 8;
    if (k < 4 + t_waits) return (p == 7) && (k == 3 + t_waits);
    if (!t_rd) return 1'b0;
    j = k - 4 - t_waits;
    v = rpat(t_base + j);
    return v[7-p];
  endfunction

  always @(posedge spi_sck) begin
    t_rise = $time;
    t_sh = {t_sh[6:0], spi_mosi};
    t_bits++;
    if (t_bits % 8 == 0 && t_bits / 8 <= 256) fb[t_bits/8-1] = t_sh;
  end

  always @(negedge spi_cs_n or negedge spi_sck) begin
    if (t_bits == 0) begin
      if (t_frames > 0 && ($time - t_hi) < 2 * (int'(cfg_div) + 1) * CLK_PERIOD) e_gap++;
    end else if (!spi_sck && ($time - t_rise) != (int'(cfg_div) + 1) * CLK_PERIOD) e_half++;
    spi_miso = miso_bit(t_bits);
  end

  always @(posedge spi_cs_n) begin
    if (t_bits > 0) begin
      int nb, fl;
      logic [7:0] hx;
      nb = t_bits / 8;
      if (t_bits % 8 != 0) e_len++;
      fl = (t_remain > MAXF) ? MAXF : t_remain;
      hx = 8'((t_rd ? 128 : 0) + fl - 1);
      if (fb[0] != hx) e_hdr++;
      if (fb[1] != 8'hD4 || fb[2] != t_addr[15:8] || fb[3] != t_addr[7:0]) e_addr++;
      if (t_waits > t_limit) begin
        if (nb != 4 + t_limit) e_len++;
        for (int i = 4; i < nb && i < 256; i++) if (fb[i] != 8'h00) e_poll++;
      end else begin
        if (nb != 4 + t_waits + fl) e_len++;
        for (int i = 4; i < 4 + t_waits; i++) if (fb[i] != 8'h00) e_poll++;
        for (int j = 0; j < fl; j++) begin
          if (t_rd) begin
            if (fb[4+t_waits+j] != 8'h00) e_rmosi++;
          end else begin
            if (fb[4+t_waits+j] != wpat(t_wglob)) e_wdata++;
            t_wglob++;
          end
        end
        t_base += fl;
        t_remain -= fl;
      end
      t_frames++;
      t_hi = $time;
      t_bits = 0;
    end
  end

  // write stream: index advances the cycle after a handshake
  assign wr_data = wpat(wr_idx);
  always @(negedge clk) begin
    if (take) wr_idx++;
    take = wr_valid && wr_ready;
  end

  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_data != rpat(rd_seen)) e_rd++;
      rd_seen++;
    end
  end

  task automatic summary_and_end();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
    summary_and_end();
  end

  task automatic do_req(input bit rd, input logic [15:0] addr, input int len,
                        input int waits, input int limit, input int div);
    int n, exp_frames, wr_before;
    bit exp_to;
    exp_to = (len > 0) && (waits > limit);
    exp_frames = (len == 0) ? 0 : (exp_to ? 1 : (len + MAXF - 1) / MAXF);
    @(negedge clk);
    cfg_div = DIVW'(div);
    cfg_wait_limit = WAITW'(limit);
    t_rd = rd; t_addr = addr; t_waits = waits; t_limit = limit;
    t_remain = len; t_base = 0; t_frames = 0;
    e_hdr = 0; e_addr = 0; e_poll = 0; e_len = 0; e_wdata = 0;
    e_rmosi = 0; e_gap = 0; e_half = 0; e_rd = 0; rd_seen = 0;
    wr_before = wr_idx;
    check(req_ready == 1'b1, "R11 idle ready", int'(req_ready), 1);
    req_read = rd; req_addr = addr; req_len = LEN_W'(len);
    req_valid = 1'b1; wr_valid = !rd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 30000) begin
      @(negedge clk);
      n++;
    end
    check(n < 30000, "R11 response", n, 0);
    check(rsp_timeout == exp_to, exp_to ? "R6 timeout flag" : "R11 ok flag",
          int'(rsp_timeout), int'(exp_to));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 pulse", int'(rsp_valid), 0);
    @(negedge clk);
    wr_valid = 1'b0;
    if (len == 0) check(t_frames == 0, "R12 no frame", t_frames, 0);
    else check(t_frames == exp_frames, "R7 frame count", t_frames, exp_frames);
    check(e_hdr == 0, "R1 header", e_hdr, 0);
    check(e_addr == 0, "R2 start/address", e_addr, 0);
    check(e_poll == 0, "R5 wait bytes", e_poll, 0);
    check(e_len == 0, waits == 0 ? "R4 frame bytes" : (exp_to ? "R6 frame bytes" : "R5 frame bytes"), e_len, 0);
    check(e_gap == 0, "R8 cs gap", e_gap, 0);
    check(e_half == 0, "R13 sck high", e_half, 0);
    check(e_wdata == 0, "R9 write data", e_wdata, 0);
    check(e_rmosi == 0, "R3 read mosi", e_rmosi, 0);
    check(e_rd == 0, "R10 read data", e_rd, 0);
    check(rd_seen == ((rd && !exp_to) ? len : 0), "R10 read count", rd_seen, (rd && !exp_to) ? len : 0);
    check(wr_idx - wr_before == ((!rd && !exp_to) ? len : 0), "R9 write count",
          wr_idx - wr_before, (!rd && !exp_to) ? len : 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_read = 1'b0; req_addr = '0; req_len = '0;
    wr_valid = 1'b0; cfg_div = '0; cfg_wait_limit = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R3 reset cs", int'(spi_cs_n), 1);
    check(spi_sck == 1'b0, "R3 reset sck", int'(spi_sck), 0);
    check(req_ready == 1'b1, "R11 reset ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R11 reset rsp", int'(rsp_valid), 0);

    // length sweep, fast clock, no waits
    for (int len = 0; len <= 20; len++)
      for (int rd = 0; rd < 2; rd++)
        do_req(rd[0], 16'h0F24 + 16'(len * 3), len, 0, 2, 0);

    // waits up to the limit with slower dividers
    for (int div = 1; div <= 2; div++)
      for (int w = 0; w <= 3; w++)
        for (int rd = 0; rd < 2; rd++) begin
          do_req(rd[0], 16'hA5C3, 1, w, 3, div);
          do_req(rd[0], 16'h0018, 9, w, 3, div);
          do_req(rd[0], 16'h7E01, 17, w, 3, div);
        end

    // timeouts
    do_req(1'b1, 16'h0024, 5, 4, 3, 1);
    do_req(1'b0, 16'h0024, 5, 4, 3, 1);
    do_req(1'b1, 16'h1234, 3, 1, 0, 0);
    do_req(1'b0, 16'h1234, 3, 0, 0, 0);
    do_req(1'b0, 16'h4321, 12, 2, 2, 0);

    summary_and_end();
  end
endmodule